// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns one asynchronous serial line into received words. A 13-bit programmable divider of the system clock produces a sample tick at sixteen times the bit rate. The divisor is the clock frequency divided by sixteen times the baud rate, rounded: 156 gives 9600 baud from a 24 MHz clock. The line passes through a two-stage synchronizer. A start search then qualifies start bits by a vote on three sub-samples, and each later bit takes its value from a vote on the three sub-samples in the middle of its period.

A frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. When parity checking is on, the last data bit received is the parity bit. The whole received word, parity bit included, is delivered on a valid/ready output. The word and its status flags wait in a single holding register until the consumer takes them. Back-pressure rule: `out_valid` stays high and `out_data` and the flags stay stable until a cycle with `out_valid` and `out_ready` both high. That handshake empties the register and clears every flag. If a frame completes while the register is full and no handshake happens in that cycle, the new frame is dropped and only the overrun flag is raised. The line-level flag `rx_active` tells whether a reception is under way.

Top module: `oversample_rx`

## Requirements
- R1: The sample tick fires once every `divisor` clock cycles, so one bit lasts 16 x `divisor` clocks. A divisor of 0 stops the receiver.
- R2: A start bit is accepted only after at least three high sample ticks followed by a low sample, counted as sub-sample 1. Sub-samples 3, 5 and 7 must then be mostly low. If the vote fails, the receiver goes back to searching, and no output or flag changes.
- R3: Each data bit and the stop bit take the majority value of sub-samples 8, 9 and 10 of their bit period. Data bits are received least significant bit first.
- R4: With `fmt9`=0 a frame carries 8 data bits, placed in `out_data[7:0]` with `out_data[8]`=0. With `fmt9`=1 it carries 9 data bits, and the ninth lands in `out_data[8]`.
- R5: With `par_en`=1 the last data bit is parity. `par_odd`=0 expects an even number of ones across all data bits and `par_odd`=1 an odd number. A mismatch raises `err_parity`. With `par_en`=0, `err_parity` stays 0.
- R6: `err_frame` rises with the word when the stop bit vote gives 0.
- R7: `out_valid` rises when a frame completes. While `out_ready` is low, `out_valid`, `out_data` and the flags hold. A handshake cycle clears `out_valid` and all five flags.
- R8: A frame that completes while `out_valid`=1 and `out_ready`=0 sets `err_overrun`. The held word and its other flags are kept.
- R9: `err_noise` rises with the word when any of the frame's start, data or stop votes was not unanimous. An overrun leaves it unchanged.
- R10: `rx_active` is 0 after reset and goes to 1 on a qualified falling edge. It returns to 0 after the line has been high for one character time (16 x (frame bits) sample ticks in a row).
- R11: A frame that completes in the same cycle as a handshake loads the new word with `out_valid` still 1 and does not set `err_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| divisor | input | 13 | Clocks per sample tick; 0 halts |
| fmt9 | input | 1 | 1 = nine data bits, 0 = eight |
| par_en | input | 1 | Treat the last data bit as parity |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| out_data | output | 9 | Received word |
| out_valid | output | 1 | Holding register full |
| out_ready | input | 1 | Consumer accepts the word |
| err_frame | output | 1 | Stop bit sampled low |
| err_overrun | output | 1 | A frame was lost while full |
| err_noise | output | 1 | A vote in the frame was not unanimous |
| err_parity | output | 1 | Parity mismatch |
| rx_active | output | 1 | Reception in progress |

## Verification
Frame completion and the consumer's handshake can fall in the same clock cycle. In that case the outgoing word must leave and the new one must be loaded, with no overrun. To force this, the bench runs at a divisor of 1 so the latency from the line to the holding register is an exact number of clocks. It raises `out_ready` for the single cycle in which the stop-bit vote reaches the register. The cycle after, `out_valid` must still be high with the second word and `err_overrun` must be low. A separate case withholds `out_ready` across two frames to check the overrun path.

// File: rtl/ovrx_pkg.sv
`timescale 1ns/1ps
package ovrx_pkg;
  localparam int OSR     = 16;
  localparam int ST_V0   = 3;
  localparam int ST_V1   = 5;
  localparam int ST_V2   = 7;
  localparam int BIT_V0  = 8;
  localparam int BIT_V1  = 9;
  localparam int BIT_V2  = 10;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic frame;
    logic parity;
    logic noise;
  } rx_flags_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic agree3(input logic a, input logic b, input logic c);
    return (a == b) && (b == c);
  endfunction
endpackage

// File: rtl/ovrx_baud.sv
`timescale 1ns/1ps
module ovrx_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (divisor != '0) && (cnt >= divisor - 1'b1);
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (divisor == '0)  cnt <= '0;
    else if (wrap)           cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ovrx_sync.sv
`timescale 1ns/1ps
module ovrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ovrx_deframer.sv
`timescale 1ns/1ps
module ovrx_deframer
  import ovrx_pkg::*;
#(
  parameter int WORD_W    = 9,
  parameter int IDLE_NEED = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              fmt9,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              start_seen,
  output logic              done,
  output logic [WORD_W-1:0] res_word,
  output rx_flags_t         res_flags
);
  localparam int SUB_W = $clog2(OSR + 1);
  localparam int IDX_W = $clog2(WORD_W + 1);
  localparam int HC_W  = $clog2(IDLE_NEED + 1);

  rx_state_e         state;
  logic [SUB_W-1:0]  sub;
  logic [SUB_W-1:0]  nsub;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic [HC_W-1:0]   hi_cnt;
  logic              v0, v1;
  logic              vote, clean;
  logic [WORD_W-1:0] shreg;
  logic              noise_acc;

  always_comb begin
    nsub     = sub + 1'b1;
    last_idx = fmt9 ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W - 2);
    vote     = maj3(v0, v1, rx_s);
    clean    = agree3(v0, v1, rx_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_HUNT;
      sub        <= '0;
      bit_idx    <= '0;
      hi_cnt     <= '0;
      v0         <= 1'b1;
      v1         <= 1'b1;
      shreg      <= '0;
      noise_acc  <= 1'b0;
      start_seen <= 1'b0;
      done       <= 1'b0;
      res_word   <= '0;
      res_flags  <= '0;
    end else begin
      start_seen <= 1'b0;
      done       <= 1'b0;
      if (tick) begin
        case (state)
          RX_HUNT: begin
            if (rx_s) begin
              if (hi_cnt != HC_W'(IDLE_NEED)) hi_cnt <= hi_cnt + 1'b1;
            end else if (hi_cnt == HC_W'(IDLE_NEED)) begin
              state      <= RX_START;
              sub        <= SUB_W'(1);
              hi_cnt     <= '0;
              start_seen <= 1'b1;
            end else begin
              hi_cnt <= '0;
            end
          end
          RX_START: begin
            sub <= nsub;
            if (nsub == SUB_W'(ST_V0)) v0 <= rx_s;
            if (nsub == SUB_W'(ST_V1)) v1 <= rx_s;
            if (nsub == SUB_W'(ST_V2)) begin
              if (vote) begin
                state  <= RX_HUNT;
                sub    <= '0;
                hi_cnt <= '0;
              end else begin
                noise_acc <= !clean;
                shreg     <= '0;
              end
            end
            if (nsub == SUB_W'(OSR)) begin
              state   <= RX_DATA;
              sub     <= '0;
              bit_idx <= '0;
            end
          end
          RX_DATA, RX_STOP: begin
            sub <= nsub;
            if (nsub == SUB_W'(BIT_V0)) v0 <= rx_s;
            if (nsub == SUB_W'(BIT_V1)) v1 <= rx_s;
            if (nsub == SUB_W'(BIT_V2)) begin
              if (state == RX_DATA) begin
                shreg[bit_idx] <= vote;
                noise_acc      <= noise_acc | !clean;
              end else begin
                done             <= 1'b1;
                res_word         <= shreg;
                res_flags.frame  <= !vote;
                res_flags.parity <= par_en && ((^shreg) != par_odd);
                res_flags.noise  <= noise_acc | !clean;
                state            <= RX_HUNT;
                sub              <= '0;
                hi_cnt           <= vote ? HC_W'(IDLE_NEED) : '0;
              end
            end
            if (state == RX_DATA && nsub == SUB_W'(OSR)) begin
              sub <= '0;
              if (bit_idx == last_idx) state   <= RX_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end
          end
          default: state <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/ovrx_activity.sv
`timescale 1ns/1ps
module ovrx_activity
  import ovrx_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  input  logic fmt9,
  input  logic start_seen,
  output logic active
);
  localparam int LONG_RUN  = (WORD_W + 2) * OSR;
  localparam int SHORT_RUN = (WORD_W + 1) * OSR;
  localparam int CNT_W     = $clog2(LONG_RUN + 1);

  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] run_last;

  assign run_last = fmt9 ? CNT_W'(LONG_RUN - 1) : CNT_W'(SHORT_RUN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      active <= 1'b0;
    end else begin
      if (tick) begin
        if (!rx_s)               run <= '0;
        else if (run < run_last) run <= run + 1'b1;
      end
      if (start_seen)                                active <= 1'b1;
      else if (tick && rx_s && (run >= run_last))    active <= 1'b0;
    end
  end
endmodule

// File: rtl/ovrx_holdreg.sv
`timescale 1ns/1ps
module ovrx_holdreg
  import ovrx_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] in_word,
  input  rx_flags_t         in_flags,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output rx_flags_t         flags,
  output logic              overrun
);
  logic take;
  assign take = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      flags     <= '0;
      overrun   <= 1'b0;
    end else if (done) begin
      if (out_valid && !take) begin
        overrun <= 1'b1;
      end else begin
        out_data  <= in_word;
        out_valid <= 1'b1;
        flags     <= in_flags;
        overrun   <= 1'b0;
      end
    end else if (take) begin
      out_valid <= 1'b0;
      flags     <= '0;
      overrun   <= 1'b0;
    end
  end
endmodule

// File: rtl/oversample_rx.sv
`timescale 1ns/1ps
module oversample_rx
  import ovrx_pkg::*;
#(
  parameter int DIV_W       = 13,
  parameter int WORD_W      = 9,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_NEED   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              fmt9,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              err_noise,
  output logic              err_parity,
  output logic              rx_active
);
  logic              tick;
  logic              rx_s;
  logic              start_seen;
  logic              frame_done;
  logic [WORD_W-1:0] frame_word;
  rx_flags_t         frame_flags;
  rx_flags_t         held_flags;

  ovrx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  ovrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  ovrx_deframer #(.WORD_W(WORD_W), .IDLE_NEED(IDLE_NEED)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
    .fmt9(fmt9), .par_en(par_en), .par_odd(par_odd),
    .start_seen(start_seen), .done(frame_done),
    .res_word(frame_word), .res_flags(frame_flags)
  );

  ovrx_activity #(.WORD_W(WORD_W)) u_activity (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
    .fmt9(fmt9), .start_seen(start_seen), .active(rx_active)
  );

  ovrx_holdreg #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .done(frame_done),
    .in_word(frame_word), .in_flags(frame_flags),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
    .flags(held_flags), .overrun(err_overrun)
  );

  assign err_frame  = held_flags.frame;
  assign err_parity = held_flags.parity;
  assign err_noise  = held_flags.noise;
endmodule

// File: rtl/ovrx_checker.sv
`timescale 1ns/1ps
module ovrx_checker #(
  parameter int DIV_W  = 13,
  parameter int WORD_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIV_W-1:0]  divisor,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              err_frame,
  input logic              err_overrun,
  input logic              err_noise,
  input logic              err_parity,
  input logic              rx_active,
  input logic              tick,
  input logic              frame_done,
  input logic              start_seen
);
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (divisor > 1) && $stable(divisor) |=> !tick);

  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));

  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !frame_done |=>
      !out_valid && !err_overrun && !err_noise && !err_frame && !err_parity);

  p_overrun_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && out_valid && !out_ready |=> err_overrun && $stable(out_data));

  p_noise_kept_on_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && out_valid && !out_ready |=> $stable(err_noise));

  p_flags_need_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_noise || err_frame || err_parity || err_overrun) |-> out_valid);

  p_start_raises_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> rx_active);

  p_done_inside_activity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> rx_active);

  p_coincide_no_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && out_valid && out_ready |=> out_valid && !err_overrun);
endmodule

bind oversample_rx ovrx_checker #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .err_frame(err_frame),
  .err_overrun(err_overrun), .err_noise(err_noise), .err_parity(err_parity),
  .rx_active(rx_active), .tick(tick), .frame_done(frame_done),
  .start_seen(start_seen)
);

// File: tb/oversample_rx_test.sv
`timescale 1ns/1ps
module oversample_rx_test;
  localparam int WW = 9;
  localparam int DW = 13;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rxd;
  logic [DW-1:0] divisor;
  logic          fmt9, par_en, par_odd;
  logic [WW-1:0] out_data;
  logic          out_valid, out_ready;
  logic          err_frame, err_overrun, err_noise, err_parity, rx_active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  oversample_rx uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .divisor(divisor),
    .fmt9(fmt9), .par_en(par_en), .par_odd(par_odd),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .err_frame(err_frame), .err_overrun(err_overrun), .err_noise(err_noise),
    .err_parity(err_parity), .rx_active(rx_active)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog (all R): actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] mk_word(input logic [8:0] raw, input logic f9,
                                          input logic pe, input logic po, input logic bad);
    logic [8:0] w;
    logic p;
    int n;
    n = f9 ? 9 : 8;
    w = raw & (f9 ? 9'h1FF : 9'h0FF);
    if (pe) begin
      p = po ^ bad;
      for (int i = 0; i < n - 1; i++) p = p ^ w[i];
      w[n-1] = p;
    end
    return w;
  endfunction

  // frame bit 0 is the start bit; glitch flips one sub-sample window
  task automatic send(input logic [8:0] w, input logic f9, input logic stopv, input int d,
                      input int gbit, input int gsub, input int gap_bits);
    logic [10:0] fb;
    int n;
    n = f9 ? 9 : 8;
    fb = '1;
    fb[0] = 1'b0;
    for (int i = 0; i < n; i++) fb[i+1] = w[i];
    fb[n+1] = stopv;
    for (int b = 0; b < n + 2; b++) begin
      for (int s = 1; s <= 16; s++) begin
        rxd = fb[b] ^ ((b == gbit) && (s == gsub));
        repeat (d) @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (gap_bits * 16 * d) @(negedge clk);
  endtask

  task automatic expect_word(input string req, input logic [8:0] w, input logic fe,
                             input logic pe, input logic nz, input logic ov);
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "out_data", int'(out_data), int'(w));
    chk(req, "err_frame", int'(err_frame), int'(fe));
    chk(req, "err_parity", int'(err_parity), int'(pe));
    chk(req, "err_noise", int'(err_noise), int'(nz));
    chk(req, "err_overrun", int'(err_overrun), int'(ov));
  endtask

  task automatic take_word(input string req);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(req, "valid after read", int'(out_valid), 0);
    chk(req, "flags after read",
        int'({err_frame, err_parity, err_noise, err_overrun}), 0);
  endtask

  initial begin
    logic [8:0] w1, w2;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; rxd = 1'b1; divisor = DW'(4);
    fmt9 = 1'b0; par_en = 1'b0; par_odd = 1'b0; out_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R7, R10)
    chk("R7", "reset valid", int'(out_valid), 0);
    chk("R7", "reset flags", int'({err_frame, err_parity, err_noise, err_overrun}), 0);
    chk("R10", "reset active", int'(rx_active), 0);
    repeat (64) @(negedge clk);

    // R1 R3 R4: plain 8-bit word, LSB first
    send(9'h067, 1'b0, 1'b1, 4, -1, 0, 2);
    expect_word("R3", 9'h067, 0, 0, 0, 0);
    chk("R10", "active just after frame", int'(rx_active), 1);
    take_word("R7");

    // R10: one full idle character clears activity
    repeat (12 * 16 * 4) @(negedge clk);
    chk("R10", "active after idle char", int'(rx_active), 0);

    // R4: nine-bit word
    fmt9 = 1'b1;
    send(9'h1A5, 1'b1, 1'b1, 4, -1, 0, 2);
    expect_word("R4", 9'h1A5, 0, 0, 0, 0);
    take_word("R7");

    // R3 R9: single-window glitch inside the vote window of data bit 3
    send(9'h0F0, 1'b1, 1'b1, 4, 4, 9, 2);
    expect_word("R9", 9'h0F0, 0, 0, 1, 0);
    take_word("R7");

    // R2: too-short low pulse is rejected without any output change
    rxd = 1'b0;
    repeat (2 * 4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * 16 * 4) @(negedge clk);
    chk("R2", "valid after rejected start", int'(out_valid), 0);
    chk("R2", "flags after rejected start",
        int'({err_frame, err_parity, err_noise, err_overrun}), 0);

    // R2 R9: one high among start votes still accepts, noise raised
    fmt9 = 1'b0;
    send(9'h03C, 1'b0, 1'b1, 4, 0, 3, 2);
    expect_word("R2", 9'h03C, 0, 0, 1, 0);
    take_word("R7");

    // R6: stop bit low
    send(9'h0AA, 1'b0, 1'b0, 4, -1, 0, 2);
    expect_word("R6", 9'h0AA, 1, 0, 0, 0);
    take_word("R7");

    // R5: four parity cases
    par_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      par_odd = k[0];
      w1 = mk_word(9'h0B3, 1'b0, 1'b1, k[0], k[1]);
      send(w1, 1'b0, 1'b1, 4, -1, 0, 2);
      expect_word("R5", w1, 0, k[1], 0, 0);
      take_word("R5");
    end
    par_en = 1'b0;

    // R8 R9: second frame lost while full; held word and flags kept
    send(9'h011, 1'b0, 1'b1, 4, 3, 8, 2);
    send(9'h013, 1'b0, 1'b0, 4, -1, 0, 2);
    expect_word("R8", 9'h011, 0, 0, 1, 1);
    take_word("R8");

    // R11 (R1 at divisor 1): handshake in the completion cycle
    divisor = DW'(1);
    repeat (40) @(negedge clk);
    send(9'h055, 1'b0, 1'b1, 1, -1, 0, 2);
    chk("R11", "first word held", int'(out_valid), 1);
    fork
      send(9'h0C3, 1'b0, 1'b1, 1, -1, 0, 2);
      begin
        repeat (16 * 9 + 10 + 3 - 1) @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R11", "valid after coincidence", int'(out_valid), 1);
        chk("R11", "new word loaded", int'(out_data), 9'h0C3);
        chk("R11", "no overrun", int'(err_overrun), 0);
        out_ready = 1'b0;
      end
    join
    take_word("R11");

    // random frames (R1 R3 R4 R5 R6 R9)
    for (int f = 0; f < 30; f++) begin
      int d, gbit, gsub, n;
      logic f9, pe, po, bad, stv;
      logic [8:0] raw;
      d   = 2 + int'($urandom % 5);
      f9  = 1'($urandom);
      pe  = 1'($urandom);
      po  = 1'($urandom);
      bad = pe & 1'($urandom);
      stv = ($urandom % 5) != 0;
      raw = 9'($urandom);
      n   = f9 ? 9 : 8;
      gbit = -1;
      gsub = 0;
      if (($urandom % 4) == 0) begin
        gbit = 1 + int'($urandom % (n + 1));
        gsub = 8 + int'($urandom % 3);
      end
      divisor = DW'(d);
      fmt9 = f9; par_en = pe; par_odd = po;
      repeat (2 * 16 * d) @(negedge clk);
      w2 = mk_word(raw, f9, pe, po, bad);
      send(w2, f9, stv, d, gbit, gsub, 2);
      expect_word("R1 random", w2, !stv, bad, gbit >= 0, 0);
      take_word("R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule